// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous on-chip request port to an external asynchronous static RAM holding 2^18 words of 16 bits. Each request is a read or a write of one word, with two byte-lane enables. The controller turns each request into a sequence of active-low strobes: chip select, output enable, write strobe and two byte-lane selects. Each phase lasts a whole number of clock cycles. That number is the RAM's minimum nanosecond figure divided by the clock period, rounded up. Changing the period and timing parameters retargets the block to a slower speed grade, for example 100 ns cycles, a 50 ns write pulse and 40 ns data setup.

The request side uses a valid/ready handshake and takes one request at a time. A read returns its word together with a one-cycle valid pulse. The bidirectional data pins appear as three signals: an output word, an output enable and an input word. The controller drives the pins only around the write strobe. It keeps the pins released long enough before and after a read that the two sides never drive them at the same time.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and after it, `req_ready` is 1, `rd_valid` is 0, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` is 0.
- R2: A read holds `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1. It then pulses `rd_valid` for exactly one cycle, RD_CYC = ceil(max(T_RC, T_AA, T_OE) / CLK_NS) rising edges after the edge that accepts it (9 with the defaults). `rd_data` then holds the word present at the pins on that final edge.
- R3: In `rd_data`, a lane whose enable is 0 reads as zero. Enable bit 0 covers data bits 7:0 and `sram_lb_n`. Enable bit 1 covers bits 15:8 and `sram_ub_n`.
- R4: A write holds `sram_we_n` at 0 for WP_CYC = ceil(max(T_WP, T_DW) / CLK_NS) consecutive cycles (5 with the defaults). Throughout that pulse, `sram_ce_n` is 0, `sram_oe_n` is 1 and the write data is driven.
- R5: `sram_addr` changes only while `sram_we_n` is 1, and it stays constant while `sram_we_n` is 0.
- R6: `sram_dq_oe` is 1 only during the write strobe and the one hold cycle after it. It is never 1 while `sram_oe_n` is 0, or in the cycle just before `sram_oe_n` falls.
- R7: A byte lane whose enable is 0 keeps its select at 1 for the whole access. The RAM byte it controls is therefore left unchanged.
- R8: `req_ready` is 1 only while the RAM is deselected (`sram_ce_n` = 1). The edge that accepts a request drops `req_ready` until that access has finished.
- R9: After a read, the write strobe of the next access begins at least ceil(T_OHZ / CLK_NS) cycles after `sram_oe_n` rises (4 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Byte-lane enables (bit 0 = low byte) |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data, disabled lanes zero |
| sram_addr | output | AW | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_lb_n | output | 1 | Low byte select, active low |
| sram_ub_n | output | 1 | High byte select, active low |
| sram_dq_out | output | DW | Data driven to the pins |
| sram_dq_oe | output | 1 | Pin driver enable |
| sram_dq_in | input | DW | Data read from the pins |

## Verification
The hardest case to reach is a read that finishes one cycle before a write begins, or a write that finishes one cycle before a read begins. Only these back-to-back turnarounds test the bus-release window and the rule against contention. The driver issues its next request in the first idle cycle, so each change of direction happens with the smallest gap the handshake allows. The bench's RAM model tracks how long the address and output enable have been stable. It returns a wrong word if a read is sampled too early, so a read phase that is too short shows up as a data mismatch.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CNT_W   = 8,
  parameter int CLK_NS  = 8,
  parameter int T_RC    = 70,
  parameter int T_AA    = 70,
  parameter int T_OE    = 35,
  parameter int T_WC    = 70,
  parameter int T_WP    = 35,
  parameter int T_DW    = 30,
  parameter int T_OHZ   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HW      = DW / 2;
  localparam int RD_CYC  = imax(1, cyc(imax(T_RC, imax(T_AA, T_OE))));
  localparam int WP_CYC  = imax(1, cyc(imax(T_WP, T_DW)));
  localparam int SU_CYC  = imax(1, cyc(T_OHZ) - 1);
  localparam int REC_CYC = imax(1, cyc(T_WC) - SU_CYC - WP_CYC);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSU, S_WP, S_WREC} state_t;

  state_t          state;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]   wdata_q;
  logic [1:0]      be_q;
  logic            last;

  assign last        = (cnt == '0);
  assign req_ready   = (state == S_IDLE);
  assign sram_ce_n   = (state == S_IDLE);
  assign sram_oe_n   = (state != S_RD);
  assign sram_we_n   = (state != S_WP);
  assign sram_lb_n   = sram_ce_n | ~be_q[0];
  assign sram_ub_n   = sram_ce_n | ~be_q[1];
  assign sram_dq_oe  = (state == S_WP) | (state == S_WREC);
  assign sram_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      sram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          wdata_q   <= req_wdata;
          be_q      <= req_be;
          if (req_write) begin
            state <= S_WSU;
            cnt   <= CNT_W'(SU_CYC - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end
        end
        S_RD: if (last) begin
          rd_data  <= {be_q[1] ? sram_dq_in[DW-1:HW] : {HW{1'b0}},
                       be_q[0] ? sram_dq_in[HW-1:0]  : {HW{1'b0}}};
          rd_valid <= 1'b1;
          state    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSU: if (last) begin
          state <= S_WP;
          cnt   <= CNT_W'(WP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WP: if (last) begin
          state <= S_WREC;
          cnt   <= CNT_W'(REC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $stable(sram_addr));
  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && !$past(sram_dq_oe)));
  // R4
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_dq_oe));
  // R2
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int AW = 18, DW = 16, CLK_NS = 8;
  localparam int RD_CYC  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WP_MIN  = (35 + CLK_NS - 1) / CLK_NS;
  localparam int OHZ_MIN = (30 + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ce_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic [AW-1:0] addr;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_dq_out(dq_out),
    .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // RAM model
  logic [15:0] mem [int];
  logic [15:0] exp_mem [int];
  int aage = 0, oage = 0, wl = 0;
  logic [AW-1:0] last_addr = '0;
  logic prev_oe_n = 1, prev_we_n = 1, prev_dq_oe = 0;
  logic [15:0] pend;
  int oe_rise_cyc = -100;

  function automatic logic [15:0] rd_word(input logic [AW-1:0] a);
    logic [15:0] w;
    w = mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    if (lb_n) w[7:0] = 8'hEE;
    if (ub_n) w[15:8] = 8'hEE;
    return w;
  endfunction

  assign dq_in = (!ce_n && !oe_n && we_n) ?
                 ((aage * CLK_NS >= 70 && oage * CLK_NS >= 35) ? rd_word(addr) : 16'hBAD1)
                 : 16'h0000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr != last_addr) begin
        chk(we_n && prev_we_n, "R5 addr change with write strobe high", {we_n, prev_we_n}, 2'b11);
        aage = 1;
      end else aage = aage + 1;
      oage = oe_n ? 0 : oage + 1;
      if (!oe_n && dq_oe) chk(0, "R6 pins driven with output enable", dq_oe, 0);
      if (prev_oe_n && !oe_n) chk(!prev_dq_oe, "R6 drive released before output enable", prev_dq_oe, 0);
      if (!prev_oe_n && oe_n) oe_rise_cyc = cyc;
      if (dq_oe && !prev_dq_oe)
        chk(cyc - oe_rise_cyc >= OHZ_MIN, "R9 read-to-write turnaround", cyc - oe_rise_cyc, OHZ_MIN);
      if (!ce_n && req_ready) chk(0, "R8 ready while selected", req_ready, 0);
      if (!we_n) begin
        wl = wl + 1;
        pend = dq_out;
        if (!dq_oe || !oe_n) chk(0, "R4 strobe without drive or with output enable", {dq_oe, oe_n}, 2'b11);
      end else if (!prev_we_n) begin
        chk(wl >= WP_MIN, "R4 write pulse width", wl, WP_MIN);
        if (!lb_n) mem[int'(addr)][7:0] = pend[7:0];
        if (!ub_n) mem[int'(addr)][15:8] = pend[15:8];
        if (!mem.exists(int'(addr))) mem[int'(addr)] = 16'h0000;
        wl = 0;
      end
    end
    last_addr = addr; prev_oe_n = oe_n; prev_we_n = we_n; prev_dq_oe = dq_oe;
  end

  // scoreboard
  logic [15:0] exp_q [$];
  string tag_q [$];
  int acc_q [$];

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !req_write) acc_q.push_back(cyc);
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected read data", rd_data, 0);
      else begin
        logic [15:0] e;
        int a, t;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        t = cyc - a;
        chk(rd_data == e, tag_q.pop_front(), rd_data, e);
        chk(t == RD_CYC + 1, "R2 read latency", t, RD_CYC + 1);
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      logic [15:0] w;
      w = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
      if (be[0]) w[7:0] = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      exp_mem[int'(a)] = w;
    end else begin
      logic [15:0] w;
      w = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
      exp_q.push_back({be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
      tag_q.push_back(tag);
    end
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rd_valid && ce_n && oe_n && we_n && !dq_oe, "R1 reset outputs",
        {req_ready, rd_valid, ce_n, oe_n, we_n, dq_oe}, 6'b101110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ce_n && oe_n && we_n && !dq_oe, "R1 idle after reset",
        {req_ready, ce_n, oe_n, we_n, dq_oe}, 5'b11110);

    issue(1, 18'h00010, 16'h1234, 2'b11, "");
    issue(0, 18'h00010, 0, 2'b11, "R2 read after write");
    issue(1, 18'h3FFFF, 16'hA5A5, 2'b11, "");
    issue(0, 18'h3FFFF, 0, 2'b11, "R2 top address");
    issue(1, 18'h00000, 16'hFFFF, 2'b11, "");
    issue(1, 18'h00000, 16'h0077, 2'b01, "");
    issue(0, 18'h00000, 0, 2'b11, "R7 low lane write only");
    issue(1, 18'h00000, 16'h8800, 2'b10, "");
    issue(0, 18'h00000, 0, 2'b01, "R3 low lane read");
    issue(0, 18'h00000, 0, 2'b10, "R3 high lane read");
    issue(1, 18'h00000, 16'h0000, 2'b00, "");
    issue(0, 18'h00000, 0, 2'b11, "R7 no lane write");
    for (int i = 0; i < 8; i++)
      issue(1, 18'(i * 18'h4A31), 16'(16'hC3A5 ^ (i * 16'h1111)), 2'b11, "");
    for (int i = 7; i >= 0; i--)
      issue(0, 18'(i * 18'h4A31), 0, 2'b11, "R2 pattern readback");
    for (int i = 0; i < 4; i++) begin
      issue(0, 18'h3FFFF, 0, 2'b11, "R9 read before write");
      issue(1, 18'h3FFFF, 16'(16'h0F0F + i), 2'b11, "");
    end
    issue(0, 18'h3FFFF, 0, 2'b11, "R2 final readback");
    repeat (2 * RD_CYC + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) chk(0, "watchdog expired", cyc, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule